// File: doc/BRIEF.md
# CAN Operating Mode Sequencer

This block decides which operating mode a CAN controller is in: reset, halt, operation, sleep, or the bus-off sub-state of operation. Software sets a two-bit mode request, a sleep bit, a two-bit bus-off recovery policy and a one-shot forced-recovery bit. The protocol engine reports reception and transmission activity, the end of each message, errors or lost arbitration that end a transmission, entry into bus-off, each run of 11 recessive bits, and a dominant bus lock.

The sequencer applies a separate wait rule to each requested mode. A forced reset is taken at once. A normal reset waits only for a transmission in progress to finish. A halt waits for any frame in progress. Halt is never entered while the bus is locked dominant. The policy field chooses where halt is entered around bus-off: never on its own, as soon as bus-off starts, when recovery ends, or on request during bus-off. Each completed mode change raises a one-cycle strobe.

Top module: `canmode_ctrl`

## Requirements
- R1: While the synchronous active-low reset is applied, and on the first cycle after it, mode_o is 0 (reset mode), busoff_o is 0 and mode_chg_o is 0.
- R2: mode_o encodes 0 = reset, 1 = halt, 2 = operation, 3 = sleep, 4 = bus-off. The request encodings are 00 = operation, 01 = reset, 10 = halt and 11 = forced reset. With the sleep bit clear, request 00 moves reset or halt to operation, and request 10 moves reset to halt, in the next cycle.
- R3: Request 11 moves operation, halt or bus-off to reset in the next cycle, whatever the reception, transmission or recovery activity.
- R4: Request 01 in operation enters reset in the next cycle when no transmission is in progress, even during reception. While tx_busy_i is high it waits, and it enters reset in the cycle after msg_end_i or tx_abort_i.
- R5: Request 10 in operation enters halt in the next cycle when neither rx_busy_i nor tx_busy_i is high. Otherwise it enters halt in the cycle after msg_end_i or tx_abort_i.
- R6: busoff_enter_i in operation moves to bus-off (mode_o 4, busoff_o 1) unless the policy is 01. Recovery ends on the 128th rec_run_i pulse in bus-off, or on force_recov_i. The block then returns to operation under policies 00 and 11. Under policy 00 a halt request made during bus-off takes effect only after the return to operation.
- R7: Under policy 01, busoff_enter_i in operation moves directly to halt in the next cycle.
- R8: Under policy 10, the end of recovery moves bus-off to halt in the next cycle.
- R9: Under policy 11, a halt request during bus-off enters halt in the next cycle, without waiting for recovery.
- R10: Request 01 during bus-off enters reset in the next cycle.
- R11: While bus_lock_i is high, halt is never entered from any mode. Reset requests are still honoured.
- R12: A set sleep bit moves reset or halt to sleep (3) in the next cycle, and it has no effect in operation or bus-off. Sleep is left only when the sleep bit is clear and the request is 01 (to reset) or 10 (to halt). Request 00 with the sleep bit clear leaves the block in sleep.
- R13: mode_chg_o is high for exactly one cycle, in the cycle when mode_o first shows a new value, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_mode_i | input | 2 | Requested mode: 00 operation, 01 reset, 10 halt, 11 forced reset |
| sleep_req_i | input | 1 | Sleep request bit |
| bo_policy_i | input | 2 | Bus-off recovery policy |
| force_recov_i | input | 1 | One-shot forced end of bus-off recovery |
| rx_busy_i | input | 1 | A frame is being received |
| tx_busy_i | input | 1 | A frame is being transmitted |
| msg_end_i | input | 1 | Pulse: the current frame has completed |
| tx_abort_i | input | 1 | Pulse: a bus error or lost arbitration ended the transmission |
| busoff_enter_i | input | 1 | Pulse: the error logic entered bus-off |
| rec_run_i | input | 1 | Pulse: 11 consecutive recessive bits were seen |
| bus_lock_i | input | 1 | The bus is locked dominant |
| mode_o | output | 3 | Current mode: 0 reset, 1 halt, 2 operation, 3 sleep, 4 bus-off |
| busoff_o | output | 1 | The block is in the bus-off sub-state |
| mode_chg_o | output | 1 | One-cycle strobe on each completed mode change |

## Verification
Every decision lands in a single mode register, so a wrong internal state shows on mode_o and mode_chg_o one cycle after the stimulus that exposed it. The exception is the recovery counter: an off-by-one or a missed clear stays hidden until the run that should end bus-off. For that reason the count is checked on both sides of the boundary, after 127 runs and after 128. The wait rules are checked by holding a request while a frame is in progress, confirming that the mode does not move, and then ending the frame.

// File: rtl/canmode_pkg.sv
// Package: shared mode, request and policy encodings for the CAN mode sequencer.
// Assumes: the encodings here are the ones visible at the block's ports.
package canmode_pkg;

    typedef enum logic [2:0] {
        MODE_RESET  = 3'd0,
        MODE_HALT   = 3'd1,
        MODE_OPER   = 3'd2,
        MODE_SLEEP  = 3'd3,
        MODE_BUSOFF = 3'd4
    } cmode_e;

    localparam logic [1:0] REQ_OPER   = 2'b00;
    localparam logic [1:0] REQ_RESET  = 2'b01;
    localparam logic [1:0] REQ_HALT   = 2'b10;
    localparam logic [1:0] REQ_FRESET = 2'b11;

    localparam logic [1:0] POL_SW  = 2'b00; // halt only on software request after recovery
    localparam logic [1:0] POL_IMM = 2'b01; // halt as soon as bus-off starts
    localparam logic [1:0] POL_END = 2'b10; // halt when recovery ends
    localparam logic [1:0] POL_REQ = 2'b11; // halt request honoured during bus-off

endpackage

// File: rtl/canmode_recov.sv
// Module: bus-off recovery counter. It counts recessive-run pulses while
// active_i is high and flags the end of recovery on the last pulse or on a
// forced recovery.
// Assumes: the caller leaves bus-off on the cycle done_o is high, so the
// count never needs to wrap.
module canmode_recov #(
    parameter int RUNS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic run_i,
    input  logic force_i,
    output logic done_o
);
    localparam int CW = (RUNS > 1) ? $clog2(RUNS) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUNS - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST);

    // Count recessive runs during bus-off, and clear outside bus-off.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            cnt_q <= '0;
        end else if (run_i && !at_last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Recovery ends on the final run or on a forced recovery.
    always_comb begin
        done_o = active_i && (force_i || (run_i && at_last));
    end

endmodule

// File: rtl/canmode_gate.sv
// Module: wait-rule gate. It decides whether a normal reset or a halt
// request may be taken in operation mode in this cycle.
// Assumes: msg_end_i and tx_abort_i are single-cycle pulses from the
// protocol engine.
module canmode_gate
    import canmode_pkg::*;
(
    input  logic [1:0] req_i,
    input  logic       rx_busy_i,
    input  logic       tx_busy_i,
    input  logic       msg_end_i,
    input  logic       tx_abort_i,
    input  logic       bus_lock_i,
    output logic       rst_go_o,
    output logic       halt_go_o
);
    logic frame_done;

    // A frame boundary is reached when the frame completes or is aborted.
    always_comb begin
        frame_done = msg_end_i || tx_abort_i;
    end

    // Normal reset waits only on a transmission; halt waits on any frame
    // and is barred while the bus is locked.
    always_comb begin
        rst_go_o  = (req_i == REQ_RESET) && (!tx_busy_i || frame_done);
        halt_go_o = (req_i == REQ_HALT) && !bus_lock_i &&
                    (!(rx_busy_i || tx_busy_i) || frame_done);
    end

endmodule

// File: rtl/canmode_fsm.sv
// Module: mode state machine. It holds the current mode, applies the
// request, sleep and bus-off policy rules, and raises a strobe on change.
// Assumes: the gate signals come from canmode_gate and rec_done_i comes
// from canmode_recov for the same cycle.
module canmode_fsm
    import canmode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_i,
    input  logic       sleep_i,
    input  logic [1:0] pol_i,
    input  logic       busoff_enter_i,
    input  logic       bus_lock_i,
    input  logic       tx_busy_i,
    input  logic       msg_end_i,
    input  logic       tx_abort_i,
    input  logic       rst_go_i,
    input  logic       halt_go_i,
    input  logic       rec_done_i,
    output cmode_e     mode_o,
    output logic       chg_o
);
    cmode_e st_q, st_d;
    logic   chg_q;
    logic   any_reset;

    assign any_reset = (req_i == REQ_RESET) || (req_i == REQ_FRESET);

    // Next-mode selection for each current mode.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MODE_RESET: begin
                if (sleep_i)                             st_d = MODE_SLEEP;
                else if (req_i == REQ_OPER)              st_d = MODE_OPER;
                else if (req_i == REQ_HALT && !bus_lock_i) st_d = MODE_HALT;
            end
            MODE_HALT: begin
                if (sleep_i)                st_d = MODE_SLEEP;
                else if (req_i == REQ_OPER) st_d = MODE_OPER;
                else if (any_reset)         st_d = MODE_RESET;
            end
            MODE_SLEEP: begin
                if (!sleep_i) begin
                    if (any_reset)                               st_d = MODE_RESET;
                    else if (req_i == REQ_HALT && !bus_lock_i)   st_d = MODE_HALT;
                end
            end
            MODE_OPER: begin
                if (req_i == REQ_FRESET)  st_d = MODE_RESET;
                else if (busoff_enter_i)  st_d = (pol_i == POL_IMM && !bus_lock_i) ? MODE_HALT : MODE_BUSOFF;
                else if (rst_go_i)        st_d = MODE_RESET;
                else if (halt_go_i)       st_d = MODE_HALT;
            end
            MODE_BUSOFF: begin
                if (any_reset)                                         st_d = MODE_RESET;
                else if (pol_i == POL_IMM && !bus_lock_i)              st_d = MODE_HALT;
                else if (pol_i == POL_REQ && req_i == REQ_HALT && !bus_lock_i) st_d = MODE_HALT;
                else if (rec_done_i)                                   st_d = (pol_i == POL_END && !bus_lock_i) ? MODE_HALT : MODE_OPER;
            end
            default: st_d = MODE_RESET;
        endcase
    end

    // Mode register and change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= MODE_RESET;
            chg_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            chg_q <= (st_d != st_q);
        end
    end

    assign mode_o = st_q;
    assign chg_o  = chg_q;

    // R3: a forced reset always lands in reset.
    assert_forced_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == REQ_FRESET && (st_q == MODE_OPER || st_q == MODE_HALT || st_q == MODE_BUSOFF))
        |=> (st_q == MODE_RESET));

    // R4: a normal reset waits for the transmission in progress.
    assert_tx_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MODE_OPER && req_i == REQ_RESET && tx_busy_i && !msg_end_i &&
         !tx_abort_i && !busoff_enter_i)
        |=> (st_q == MODE_OPER));

    // R7: policy 01 enters halt on bus-off entry.
    assert_pol_imm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MODE_OPER && busoff_enter_i && pol_i == POL_IMM && !bus_lock_i &&
         req_i != REQ_FRESET)
        |=> (st_q == MODE_HALT));

    // R11: no halt entry while the bus is locked.
    assert_no_halt_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock_i && st_q != MODE_HALT) |=> (st_q != MODE_HALT));

    // R12: sleep is reachable only from reset or halt.
    assert_sleep_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MODE_OPER || st_q == MODE_BUSOFF) |=> (st_q != MODE_SLEEP));

endmodule

// File: rtl/canmode_ctrl.sv
// Module: CAN operating mode sequencer top. It joins the wait-rule gate,
// the bus-off recovery counter and the mode state machine.
// Assumes: all inputs are synchronous to clk; the pulse inputs last one
// cycle each.
module canmode_ctrl
    import canmode_pkg::*;
#(
    parameter int RECOV_RUNS = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_mode_i,
    input  logic       sleep_req_i,
    input  logic [1:0] bo_policy_i,
    input  logic       force_recov_i,
    input  logic       rx_busy_i,
    input  logic       tx_busy_i,
    input  logic       msg_end_i,
    input  logic       tx_abort_i,
    input  logic       busoff_enter_i,
    input  logic       rec_run_i,
    input  logic       bus_lock_i,
    output logic [2:0] mode_o,
    output logic       busoff_o,
    output logic       mode_chg_o
);
    cmode_e cur_mode;
    logic   rst_go, halt_go, rec_done, in_busoff;

    assign in_busoff = (cur_mode == MODE_BUSOFF);

    canmode_gate u_gate (
        .req_i      (req_mode_i),
        .rx_busy_i  (rx_busy_i),
        .tx_busy_i  (tx_busy_i),
        .msg_end_i  (msg_end_i),
        .tx_abort_i (tx_abort_i),
        .bus_lock_i (bus_lock_i),
        .rst_go_o   (rst_go),
        .halt_go_o  (halt_go)
    );

    canmode_recov #(.RUNS(RECOV_RUNS)) u_recov (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (in_busoff),
        .run_i    (rec_run_i),
        .force_i  (force_recov_i),
        .done_o   (rec_done)
    );

    canmode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_i          (req_mode_i),
        .sleep_i        (sleep_req_i),
        .pol_i          (bo_policy_i),
        .busoff_enter_i (busoff_enter_i),
        .bus_lock_i     (bus_lock_i),
        .tx_busy_i      (tx_busy_i),
        .msg_end_i      (msg_end_i),
        .tx_abort_i     (tx_abort_i),
        .rst_go_i       (rst_go),
        .halt_go_i      (halt_go),
        .rec_done_i     (rec_done),
        .mode_o         (cur_mode),
        .chg_o          (mode_chg_o)
    );

    // Port view of the mode register.
    always_comb begin
        mode_o   = cur_mode;
        busoff_o = in_busoff;
    end

    // R13: the strobe marks exactly the cycles in which the mode changed.
    assert_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mode_chg_o == (mode_o != $past(mode_o))));

    // R6: the bus-off flag and the mode code agree.
    assert_busoff_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_o |-> (mode_o == 3'd4));

endmodule

// File: tb/canmode_ctrl_tb_top.sv
// Directed bench for the CAN mode sequencer: one task per scenario.
module canmode_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 20000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] req_mode, bo_policy;
    logic       sleep_req, force_recov, rx_busy, tx_busy, msg_end, tx_abort;
    logic       busoff_enter, rec_run, bus_lock;
    logic [2:0] mode;
    logic       busoff, mode_chg;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    localparam logic [2:0] M_RST = 3'd0, M_HALT = 3'd1, M_OPER = 3'd2, M_SLP = 3'd3, M_BO = 3'd4;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    canmode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_mode_i(req_mode), .sleep_req_i(sleep_req),
        .bo_policy_i(bo_policy), .force_recov_i(force_recov), .rx_busy_i(rx_busy),
        .tx_busy_i(tx_busy), .msg_end_i(msg_end), .tx_abort_i(tx_abort),
        .busoff_enter_i(busoff_enter), .rec_run_i(rec_run), .bus_lock_i(bus_lock),
        .mode_o(mode), .busoff_o(busoff), .mode_chg_o(mode_chg)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        req_mode = 2'b01; sleep_req = 0; bo_policy = 2'b00; force_recov = 0;
        rx_busy = 0; tx_busy = 0; msg_end = 0; tx_abort = 0;
        busoff_enter = 0; rec_run = 0; bus_lock = 0;
    endtask

    task automatic restart();
        quiet();
        rst_n = 0; tick(); rst_n = 1;
    endtask

    task automatic to_oper();
        req_mode = 2'b00; tick();
    endtask

    task automatic t_reset_r1();
        quiet(); rst_n = 0; tick(); tick();
        chk("R1 mode in reset", mode, M_RST);
        chk("R1 busoff in reset", busoff, 0);
        chk("R1 strobe in reset", mode_chg, 0);
        rst_n = 1; tick();
        chk("R1 mode after reset", mode, M_RST);
        chk("R1 strobe after reset", mode_chg, 0);
    endtask

    task automatic t_basic_r2();
        restart(); to_oper();
        chk("R2 reset->oper", mode, M_OPER);
        chk("R13 strobe on change", mode_chg, 1);
        tick();
        chk("R13 strobe one cycle", mode_chg, 0);
        restart(); req_mode = 2'b10; tick();
        chk("R2 reset->halt", mode, M_HALT);
        req_mode = 2'b00; tick();
        chk("R2 halt->oper", mode, M_OPER);
    endtask

    task automatic t_forced_r3();
        restart(); to_oper();
        rx_busy = 1; tx_busy = 1; req_mode = 2'b11; tick();
        chk("R3 forced reset during frame", mode, M_RST);
        rx_busy = 0; tx_busy = 0; to_oper();
        busoff_enter = 1; tick(); busoff_enter = 0;
        chk("R6 oper->busoff", mode, M_BO);
        req_mode = 2'b11; tick();
        chk("R3 forced reset from busoff", mode, M_RST);
    endtask

    task automatic t_reset_r4();
        restart(); to_oper();
        rx_busy = 1; req_mode = 2'b01; tick();
        chk("R4 reset during rx immediate", mode, M_RST);
        rx_busy = 0; to_oper();
        tx_busy = 1; req_mode = 2'b01; tick(); tick();
        chk("R4 reset waits on tx", mode, M_OPER);
        msg_end = 1; tick(); msg_end = 0; tx_busy = 0;
        chk("R4 reset after msg end", mode, M_RST);
        to_oper();
        tx_busy = 1; req_mode = 2'b01; tick();
        tx_abort = 1; tick(); tx_abort = 0; tx_busy = 0;
        chk("R4 reset after tx abort", mode, M_RST);
    endtask

    task automatic t_halt_r5();
        restart(); to_oper();
        req_mode = 2'b10; tick();
        chk("R5 halt idle immediate", mode, M_HALT);
        to_oper();
        rx_busy = 1; req_mode = 2'b10; tick(); tick();
        chk("R5 halt waits on rx", mode, M_OPER);
        msg_end = 1; tick(); msg_end = 0; rx_busy = 0;
        chk("R5 halt after msg end", mode, M_HALT);
        to_oper();
        tx_busy = 1; req_mode = 2'b10; tick();
        chk("R5 halt waits on tx", mode, M_OPER);
        tx_abort = 1; tick(); tx_abort = 0; tx_busy = 0;
        chk("R5 halt after tx abort", mode, M_HALT);
    endtask

    task automatic t_busoff_r6();
        restart(); bo_policy = 2'b00; to_oper();
        busoff_enter = 1; tick(); busoff_enter = 0;
        chk("R6 busoff mode", mode, M_BO);
        chk("R6 busoff flag", busoff, 1);
        req_mode = 2'b10; rec_run = 1;
        for (int i = 0; i < 127; i++) tick();
        chk("R6 still busoff after 127 runs", mode, M_BO);
        tick(); rec_run = 0;
        chk("R6 oper after 128 runs", mode, M_OPER);
        tick();
        chk("R6 halt honoured after recovery", mode, M_HALT);
        to_oper();
        busoff_enter = 1; tick(); busoff_enter = 0;
        force_recov = 1; tick(); force_recov = 0;
        chk("R6 forced recovery to oper", mode, M_OPER);
        bo_policy = 2'b11;
        busoff_enter = 1; tick(); busoff_enter = 0;
        force_recov = 1; tick(); force_recov = 0;
        chk("R6 policy 11 recovery to oper", mode, M_OPER);
    endtask

    task automatic t_policies_r7_r10();
        restart(); bo_policy = 2'b01; to_oper();
        busoff_enter = 1; tick(); busoff_enter = 0;
        chk("R7 policy 01 halt on entry", mode, M_HALT);
        restart(); bo_policy = 2'b10; to_oper();
        busoff_enter = 1; tick(); busoff_enter = 0;
        chk("R8 busoff first", mode, M_BO);
        force_recov = 1; tick(); force_recov = 0;
        chk("R8 policy 10 halt at recovery end", mode, M_HALT);
        restart(); bo_policy = 2'b11; to_oper();
        busoff_enter = 1; tick(); busoff_enter = 0;
        req_mode = 2'b10; tick();
        chk("R9 policy 11 halt during busoff", mode, M_HALT);
        restart(); to_oper();
        busoff_enter = 1; tick(); busoff_enter = 0;
        tx_busy = 1; req_mode = 2'b01; tick(); tx_busy = 0;
        chk("R10 reset during busoff", mode, M_RST);
    endtask

    task automatic t_lock_r11();
        restart(); to_oper();
        bus_lock = 1; req_mode = 2'b10; tick(); tick(); tick();
        chk("R11 no halt from oper when locked", mode, M_OPER);
        req_mode = 2'b01; tick();
        chk("R11 reset honoured when locked", mode, M_RST);
        req_mode = 2'b10; tick();
        chk("R11 no halt from reset when locked", mode, M_RST);
        bus_lock = 0; tick();
        chk("R11 halt after unlock", mode, M_HALT);
    endtask

    task automatic t_sleep_r12();
        restart(); to_oper();
        sleep_req = 1; tick(); tick();
        chk("R12 sleep ignored in oper", mode, M_OPER);
        req_mode = 2'b10; tick();
        chk("R12 halt entered with sleep set", mode, M_HALT);
        tick();
        chk("R12 halt->sleep", mode, M_SLP);
        req_mode = 2'b00; sleep_req = 0; tick(); tick();
        chk("R12 request 00 keeps sleep", mode, M_SLP);
        req_mode = 2'b01; tick();
        chk("R12 sleep->reset", mode, M_RST);
        sleep_req = 1; tick();
        chk("R12 reset->sleep", mode, M_SLP);
        sleep_req = 0; req_mode = 2'b10; tick();
        chk("R12 sleep->halt", mode, M_HALT);
    endtask

    initial begin
        quiet(); rst_n = 0;
        t_reset_r1();
        t_basic_r2();
        t_forced_r3();
        t_reset_r4();
        t_halt_r5();
        t_busoff_r6();
        t_policies_r7_r10();
        t_lock_r11();
        t_sleep_r12();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait (cyc >= MAX_CYC);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, MAX_CYC);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule